// File: doc/BRIEF.md
# Atomic Register-Memory Swap Sequencer

This block carries out one swap instruction. It takes a 32-bit instruction word together with a start strobe and decodes the word into one of four addressing forms. The forms are: an absolute address, a base register plus a signed 10-bit offset, a bit-reversed pointer walk, and a circular-buffer pointer walk. It reads the data register and the address registers it needs through combinational read ports, and a small address generator forms the effective word address. After that the sequencer runs a locked read followed by a write to the same word on a request/ready memory port.

The word read from memory ends up in the data register, and the register's earlier value ends up in memory. The two pointer forms also produce a new value for the paired address register. All register results are committed in one closing cycle, and that cycle also raises `done`. An instruction word that matches none of the four forms raises `illegal` for one cycle. Such a word causes no bus or register activity.

Top module: `swap_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `mem_req`, `mem_lock`, `done`, `illegal`, `dreg_we` and `areg_we` are all 0.
- R2: In the cycle after an accepted start, `mem_req`=1 and `mem_we`=0 (read). `mem_addr` and `mem_we` hold steady for as long as `mem_ready` is low.
- R3: The cycle after the read is accepted (`mem_ready`=1), a write (`mem_we`=1) is requested to the same `mem_addr`. It carries the data register's value as it was sampled in the start cycle.
- R4: `mem_lock` is 1 from the first read-request cycle through the cycle in which the write is accepted, and 0 in the cycle after that.
- R5: One cycle after the write is accepted, `done` pulses for exactly one cycle. In that cycle `dreg_we`=1, `dreg_waddr` = instr[11:8], and `dreg_wdata` = the word returned by the read.
- R6: Absolute form: instr[7:0]=0xE5 and instr[27:26]=0. The 18-bit offset is off[17:14]=instr[15:12], off[13:10]=instr[25:22], off[9:6]=instr[31:28] and off[5:0]=instr[21:16]. The address is {off[17:14], fourteen zeros, off[13:0]}.
- R7: Base-plus-offset form: instr[7:0]=0x49 and instr[27:22]=0x20. The address is A[instr[15:12]] plus the sign-extended 10-bit offset {instr[31:28], instr[21:16]}.
- R8: Bit-reversed form: instr[7:0]=0x69 and instr[27:22]=0x00. The paired register P = A[(b+1) mod 16] holds an increment in [31:16] and an index in [15:0]. The address is A[b] + index. P is written back as {increment, rev(rev(index)+rev(increment))}, where rev mirrors 16 bits and the sum is taken mod 2^16.
- R9: Circular form: instr[7:0]=0x69 and instr[27:22]=0x10. P holds a length in [31:16] and an index in [15:0]. The address is A[b] + index. The new index is index plus the sign-extended offset; length is added to it if the result is negative, or subtracted if the result is at least length. P is written back as {length, new index}.
- R10: A start with any other opcode combination pulses `illegal` in the next cycle and makes no memory request and no register write.
- R11: A start raised while a swap is in progress is ignored: the running swap completes unchanged and no extra bus access follows.
- R12: `dreg_we` and `areg_we` are 1 only in the `done` cycle. `areg_we` is set only for the two pointer forms, and `areg_waddr` = (b+1) mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a swap with `instr` (sampled only when idle) |
| instr | input | 32 | Swap instruction word |
| dreg_raddr | output | 4 | Data register read index |
| dreg_rdata | input | 32 | Data register read value |
| areg_raddr | output | 4 | Base address register read index |
| areg_rdata | input | 32 | Base address register value |
| apair_raddr | output | 4 | Paired address register read index |
| apair_rdata | input | 32 | Paired address register value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Bus lock held across the read and the write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` on a read |
| dreg_we | output | 1 | Data register write enable |
| dreg_waddr | output | 4 | Data register write index |
| dreg_wdata | output | 32 | Data register write value |
| areg_we | output | 1 | Paired address register write enable |
| areg_waddr | output | 4 | Paired address register write index |
| areg_wdata | output | 32 | Paired address register write value |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for an unrecognised instruction |

## Verification
The assertions check the bus protocol on every cycle. They cover the reset quiet state, the stable address and direction during wait states, the write following an accepted read at the same address, an unbroken lock up to the write acceptance, the single-cycle done pulse, and the absence of register writes outside that pulse or together with `illegal`. Only the bench's scenarios can show that the numbers are right. That covers the addresses produced by each of the four forms, the bit-reversed and circular pointer sequences (including wrap in both directions and the b=15 pairing with register 0), the exchanged contents of memory and registers, and the rejection of illegal encodings and of a start raised mid-swap.

// File: rtl/swap_seq_pkg.sv
// Shared constants, types and helpers for the swap sequencer.
// Assumes a 32-bit instruction and data word and a 16-entry register file.
package swap_seq_pkg;
    localparam int WORD_W  = 32;
    localparam int IDX_W   = 4;
    localparam int OFF_S_W = 10;
    localparam int OFF_L_W = 18;
    localparam int HALF_W  = WORD_W / 2;

    localparam logic [7:0] OPC_ABS  = 8'hE5;
    localparam logic [7:0] OPC_BOFF = 8'h49;
    localparam logic [7:0] OPC_PTR  = 8'h69;
    localparam logic [1:0] SUB_ABS  = 2'b00;
    localparam logic [5:0] SUB_BOFF = 6'h20;
    localparam logic [5:0] SUB_BREV = 6'h00;
    localparam logic [5:0] SUB_CIRC = 6'h10;

    typedef enum logic [2:0] {AM_NONE, AM_ABS, AM_BOFF, AM_BREV, AM_CIRC} amode_e;
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE} state_e;

    // Mirror the bit order of a half word.
    function automatic logic [HALF_W-1:0] rev_half(input logic [HALF_W-1:0] v);
        logic [HALF_W-1:0] r;
        for (int i = 0; i < HALF_W; i++) r[i] = v[HALF_W-1-i];
        return r;
    endfunction
endpackage

// File: rtl/swap_decode.sv
// Instruction decoder: classifies the word into one of four addressing forms
// and slices out the register indices and the scattered offset pieces.
// Assumes nothing about timing; purely combinational.
module swap_decode
    import swap_seq_pkg::*;
(
    input  logic [WORD_W-1:0]  instr,
    output amode_e             mode,
    output logic [IDX_W-1:0]   d_idx,
    output logic [IDX_W-1:0]   a_idx,
    output logic [OFF_S_W-1:0] off_s,
    output logic [OFF_L_W-1:0] off_l
);
    assign d_idx = instr[11:8];
    assign a_idx = instr[15:12];
    assign off_s = {instr[31:28], instr[21:16]};
    assign off_l = {instr[15:12], instr[25:22], instr[31:28], instr[21:16]};

    // Match primary and secondary opcode per form.
    always_comb begin
        mode = AM_NONE;
        case (instr[7:0])
            OPC_ABS:  if (instr[27:26] == SUB_ABS) mode = AM_ABS;
            OPC_BOFF: if (instr[27:22] == SUB_BOFF) mode = AM_BOFF;
            OPC_PTR: begin
                if (instr[27:22] == SUB_BREV)      mode = AM_BREV;
                else if (instr[27:22] == SUB_CIRC) mode = AM_CIRC;
            end
            default: mode = AM_NONE;
        endcase
    end
endmodule

// File: rtl/swap_agen.sv
// Address generator: forms the effective word address for the selected form
// and the updated paired pointer register for the two pointer-walk forms.
// Assumes base and pair values are the current register contents; combinational.
module swap_agen
    import swap_seq_pkg::*;
(
    input  amode_e             mode,
    input  logic [OFF_S_W-1:0] off_s,
    input  logic [OFF_L_W-1:0] off_l,
    input  logic [WORD_W-1:0]  base,
    input  logic [WORD_W-1:0]  pair,
    output logic [WORD_W-1:0]  ea,
    output logic [WORD_W-1:0]  pair_new,
    output logic               pair_upd
);
    localparam int STEP_W = HALF_W + 2;
    localparam int ABS_Z  = WORD_W - OFF_L_W;

    logic [HALF_W-1:0] idx, hi;
    logic [STEP_W-1:0] step, wrapped, hi_x;

    assign idx  = pair[HALF_W-1:0];
    assign hi   = pair[WORD_W-1:HALF_W];
    assign hi_x = {2'b00, hi};

    // Circular index step with wrap in either direction.
    always_comb begin
        step = {2'b00, idx} + {{(STEP_W-OFF_S_W){off_s[OFF_S_W-1]}}, off_s};
        if (step[STEP_W-1])   wrapped = step + hi_x;
        else if (step >= hi_x) wrapped = step - hi_x;
        else                  wrapped = step;
    end

    // Select address and pointer update by addressing form.
    always_comb begin
        ea       = '0;
        pair_new = pair;
        pair_upd = 1'b0;
        case (mode)
            AM_ABS:  ea = {off_l[OFF_L_W-1:OFF_L_W-4], {ABS_Z{1'b0}}, off_l[OFF_L_W-5:0]};
            AM_BOFF: ea = base + {{(WORD_W-OFF_S_W){off_s[OFF_S_W-1]}}, off_s};
            AM_BREV: begin
                ea       = base + {{HALF_W{1'b0}}, idx};
                pair_new = {hi, rev_half(rev_half(idx) + rev_half(hi))};
                pair_upd = 1'b1;
            end
            AM_CIRC: begin
                ea       = base + {{HALF_W{1'b0}}, idx};
                pair_new = {hi, wrapped[HALF_W-1:0]};
                pair_upd = 1'b1;
            end
            default: ea = '0;
        endcase
    end
endmodule

// File: rtl/swap_ctrl.sv
// Sequencer state machine: idle, locked read, locked write, commit.
// Assumes the memory holds a request until it answers with ready.
module swap_ctrl
    import swap_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   legal,
    input  logic   mem_ready,
    output state_e state,
    output logic   accept,
    output logic   rd_take,
    output logic   illegal_q
);
    assign accept  = (state == ST_IDLE) && start && legal;
    assign rd_take = (state == ST_READ) && mem_ready;

    // Advance through the read/write/commit sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (accept) state <= ST_READ;
                ST_READ:  if (mem_ready) state <= ST_WRITE;
                ST_WRITE: if (mem_ready) state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // One-cycle flag for a start carrying an unknown encoding.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= (state == ST_IDLE) && start && !legal;
    end
endmodule

// File: rtl/swap_seq.sv
// Atomic swap sequencer top: decodes a swap instruction, captures operands
// and address at start, runs a locked read then write of one word, and
// commits register results in a final cycle. Assumes register read ports
// are combinational and memory requests are held until ready.
module swap_seq
    import swap_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr,
    output logic [IDX_W-1:0]  dreg_raddr,
    input  logic [WORD_W-1:0] dreg_rdata,
    output logic [IDX_W-1:0]  areg_raddr,
    input  logic [WORD_W-1:0] areg_rdata,
    output logic [IDX_W-1:0]  apair_raddr,
    input  logic [WORD_W-1:0] apair_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              dreg_we,
    output logic [IDX_W-1:0]  dreg_waddr,
    output logic [WORD_W-1:0] dreg_wdata,
    output logic              areg_we,
    output logic [IDX_W-1:0]  areg_waddr,
    output logic [WORD_W-1:0] areg_wdata,
    output logic              done,
    output logic              illegal
);
    amode_e             mode;
    state_e             state;
    logic [IDX_W-1:0]   d_idx, a_idx;
    logic [OFF_S_W-1:0] off_s;
    logic [OFF_L_W-1:0] off_l;
    logic [WORD_W-1:0]  ea, pair_new;
    logic               pair_upd, accept, rd_take, legal;

    logic [IDX_W-1:0]   d_q, p_q;
    logic [WORD_W-1:0]  ea_q, wd_q, pnew_q, rd_q;
    logic               pupd_q;

    swap_decode u_dec (
        .instr (instr), .mode (mode), .d_idx (d_idx), .a_idx (a_idx),
        .off_s (off_s), .off_l (off_l)
    );

    swap_agen u_agen (
        .mode (mode), .off_s (off_s), .off_l (off_l), .base (areg_rdata),
        .pair (apair_rdata), .ea (ea), .pair_new (pair_new), .pair_upd (pair_upd)
    );

    assign legal = (mode != AM_NONE);

    swap_ctrl u_ctrl (
        .clk (clk), .rst_n (rst_n), .start (start), .legal (legal),
        .mem_ready (mem_ready), .state (state), .accept (accept),
        .rd_take (rd_take), .illegal_q (illegal)
    );

    assign dreg_raddr  = d_idx;
    assign areg_raddr  = a_idx;
    assign apair_raddr = a_idx + 1'b1;

    // Capture operands, address and pointer update when a swap is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q    <= '0;
            p_q    <= '0;
            ea_q   <= '0;
            wd_q   <= '0;
            pnew_q <= '0;
            pupd_q <= 1'b0;
        end else if (accept) begin
            d_q    <= d_idx;
            p_q    <= apair_raddr;
            ea_q   <= ea;
            wd_q   <= dreg_rdata;
            pnew_q <= pair_new;
            pupd_q <= pair_upd;
        end
    end

    // Hold the old memory word once the read is answered.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (rd_take) rd_q <= mem_rdata;
    end

    assign mem_req    = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we     = (state == ST_WRITE);
    assign mem_lock   = mem_req;
    assign mem_addr   = ea_q;
    assign mem_wdata  = wd_q;
    assign done       = (state == ST_DONE);
    assign dreg_we    = done;
    assign dreg_waddr = d_q;
    assign dreg_wdata = rd_q;
    assign areg_we    = done && pupd_q;
    assign areg_waddr = p_q;
    assign areg_wdata = pnew_q;
endmodule

// File: rtl/swap_seq_chk.sv
// Protocol checker for the swap sequencer, bound to every instance.
module swap_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_lock,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic        done,
    input logic        illegal,
    input logic        dreg_we,
    input logic        areg_we
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!mem_req && !mem_lock && !done && !illegal && !dreg_we && !areg_we)); // R1
    AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2
    AST_WRITE_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we && mem_addr == $past(mem_addr))); // R3
    AST_LOCK_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n) (mem_lock && !(mem_we && mem_ready)) |=> mem_lock); // R4
    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we && mem_ready) |=> (!mem_lock && done)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> (!mem_req && !dreg_we && !areg_we)); // R10
    AST_COMMIT_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n) (dreg_we || areg_we) |-> done); // R12
endmodule

bind swap_seq swap_seq_chk u_chk (
    .clk (clk), .rst_n (rst_n), .mem_req (mem_req), .mem_we (mem_we),
    .mem_lock (mem_lock), .mem_ready (mem_ready), .mem_addr (mem_addr),
    .done (done), .illegal (illegal), .dreg_we (dreg_we), .areg_we (areg_we)
);

// File: tb/tb_swap_seq.sv
module tb_swap_seq;
    logic        clk = 1'b0;
    logic        rst_n, start;
    logic [31:0] instr;
    logic [3:0]  dreg_raddr, areg_raddr, apair_raddr, dreg_waddr, areg_waddr;
    logic [31:0] dreg_rdata, areg_rdata, apair_rdata, mem_addr, mem_wdata, mem_rdata;
    logic [31:0] dreg_wdata, areg_wdata;
    logic        mem_req, mem_we, mem_lock, mem_ready, dreg_we, areg_we, done, illegal;

    always #5 clk = ~clk;

    swap_seq dut (.*);

    logic [31:0] D [16];
    logic [31:0] A [16];
    logic [31:0] mem [logic [31:0]];
    assign dreg_rdata  = D[dreg_raddr];
    assign areg_rdata  = A[areg_raddr];
    assign apair_rdata = A[apair_raddr];

    int total = 0, bad = 0, nwr = 0, wcnt = 0, rdelay = 0, est = 0;
    logic eill = 1'b0, finished = 1'b0;
    logic [31:0] exp_ea, exp_wd, exp_rd, exp_pnew;
    logic [3:0]  exp_a, exp_p;
    logic        exp_pupd = 1'b0;
    string       mtag = "R6";

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] mread(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'hA5A5_0000;
    endfunction

    function automatic logic [15:0] flip(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[15-i] = v[i];
        return r;
    endfunction

    function automatic bit legal_of(input logic [31:0] w);
        if (w[7:0] == 8'hE5) return w[27:26] == 2'b00;
        if (w[7:0] == 8'h49) return w[27:22] == 6'h20;
        if (w[7:0] == 8'h69) return (w[27:22] == 6'h00) || (w[27:22] == 6'h10);
        return 1'b0;
    endfunction

    function automatic logic [31:0] mk_bo(input logic [7:0] op, input logic [5:0] sub,
                                          input logic [3:0] a, input logic [3:0] b, input logic [9:0] off);
        return {off[9:6], sub, off[5:0], b, a, op};
    endfunction

    function automatic logic [31:0] mk_abs(input logic [3:0] a, input logic [17:0] off);
        return {off[9:6], 2'b00, off[13:10], off[5:0], off[17:14], a, 8'hE5};
    endfunction

    // Reference model state: 0 idle, 1 read, 2 write, 3 commit.
    always @(posedge clk) begin
        if (!rst_n) begin
            est  = 0;
            eill = 1'b0;
        end else begin
            eill = (est == 0) && start && !legal_of(instr);
            case (est)
                0: if (start && legal_of(instr)) est = 1;
                1: if (mem_ready) est = 2;
                2: if (mem_ready) est = 3;
                default: est = 0;
            endcase
        end
    end

    // Compare every cycle, then act as memory and register file.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(mem_req === (est == 1 || est == 2), "R2 req", {31'd0, mem_req}, {31'd0, est == 1 || est == 2});
            chk(mem_lock === (est == 1 || est == 2), "R4 lock", {31'd0, mem_lock}, {31'd0, est == 1 || est == 2});
            chk(mem_we === (est == 2), "R3 we", {31'd0, mem_we}, {31'd0, est == 2});
            chk(done === (est == 3), "R5 done", {31'd0, done}, {31'd0, est == 3});
            chk(illegal === eill, "R10 illegal", {31'd0, illegal}, {31'd0, eill});
            chk(dreg_we === (est == 3), "R12 dreg_we", {31'd0, dreg_we}, {31'd0, est == 3});
            chk(areg_we === (est == 3 && exp_pupd), "R12 areg_we", {31'd0, areg_we}, {31'd0, est == 3 && exp_pupd});
            if (est == 1 || est == 2) chk(mem_addr === exp_ea, mtag, mem_addr, exp_ea);
            if (est == 2) chk(mem_wdata === exp_wd, "R3 wdata", mem_wdata, exp_wd);
            if (est == 3) begin
                chk(dreg_waddr === exp_a, "R5 waddr", {28'd0, dreg_waddr}, {28'd0, exp_a});
                chk(dreg_wdata === exp_rd, "R5 wdata", dreg_wdata, exp_rd);
                if (exp_pupd) begin
                    chk(areg_waddr === exp_p, "R12 pair index", {28'd0, areg_waddr}, {28'd0, exp_p});
                    chk(areg_wdata === exp_pnew, mtag, areg_wdata, exp_pnew);
                end
            end
        end
        mem_ready = mem_req && (wcnt >= rdelay);
        mem_rdata = mread(mem_addr);
        if (mem_req && mem_we && mem_ready) begin
            mem[mem_addr] = mem_wdata;
            nwr++;
        end
        if (dreg_we) D[dreg_waddr] = dreg_wdata;
        if (areg_we) A[areg_waddr] = areg_wdata;
        if (mem_req && mem_ready) wcnt = 0;
        else if (mem_req) wcnt++;
    end

    // Expected results of a swap, from the register and memory model.
    task automatic prep(input logic [31:0] w);
        logic [3:0]  b;
        logic [9:0]  o10;
        logic [17:0] o18;
        logic [15:0] idx, hi;
        int          s, ni;
        exp_a = w[11:8];
        b     = w[15:12];
        exp_p = b + 4'd1;
        o10   = {w[31:28], w[21:16]};
        o18   = {w[15:12], w[25:22], w[31:28], w[21:16]};
        idx   = A[exp_p][15:0];
        hi    = A[exp_p][31:16];
        s     = int'(o10);
        if (o10[9]) s = s - 1024;
        exp_pupd = 1'b0;
        exp_pnew = A[exp_p];
        if (w[7:0] == 8'hE5) begin
            mtag   = "R6 abs";
            exp_ea = (32'(o18 >> 14) << 28) | 32'(o18[13:0]);
        end else if (w[7:0] == 8'h49) begin
            mtag   = "R7 base+off";
            exp_ea = A[b] + 32'(s);
        end else if (w[27:22] == 6'h00) begin
            mtag     = "R8 bitrev";
            exp_ea   = A[b] + 32'(idx);
            exp_pupd = 1'b1;
            exp_pnew = {hi, flip(flip(idx) + flip(hi))};
        end else begin
            mtag   = "R9 circ";
            exp_ea = A[b] + 32'(idx);
            ni     = int'(idx) + s;
            if (ni < 0) ni = ni + int'(hi);
            else if (ni >= int'(hi)) ni = ni - int'(hi);
            exp_pupd = 1'b1;
            exp_pnew = {hi, ni[15:0]};
        end
        exp_wd = D[exp_a];
        exp_rd = mread(exp_ea);
    endtask

    task automatic finish_checks(input int wr0);
        chk(D[exp_a] === exp_rd, "R5 reg gets old word", D[exp_a], exp_rd);
        chk(mread(exp_ea) === exp_wd, "R3 word gets old reg", mread(exp_ea), exp_wd);
        chk(nwr - wr0 == 1, "R11 one write per swap", 32'(nwr - wr0), 32'd1);
        if (exp_pupd) chk(A[exp_p] === exp_pnew, mtag, A[exp_p], exp_pnew);
    endtask

    task automatic run(input logic [31:0] w, input int dly);
        int wr0;
        @(negedge clk);
        rdelay = dly;
        wr0    = nwr;
        prep(w);
        instr = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (est != 0) @(negedge clk);
        finish_checks(wr0);
    endtask

    task automatic run_busy(input logic [31:0] w, input logic [31:0] w2, input int dly);
        int wr0;
        @(negedge clk);
        rdelay = dly;
        wr0    = nwr;
        prep(w);
        instr = w;
        start = 1'b1;
        @(negedge clk);
        instr = w2;
        @(negedge clk);
        start = 1'b0;
        while (est != 0) @(negedge clk);
        finish_checks(wr0);
        @(negedge clk);
        chk(!mem_req, "R11 no second swap", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic run_bad(input logic [31:0] w);
        logic [31:0] d0 [16];
        logic [31:0] a0 [16];
        int wr0;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin d0[i] = D[i]; a0[i] = A[i]; end
        wr0   = nwr;
        instr = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(illegal === 1'b1, "R10 flag", {31'd0, illegal}, 32'd1);
        repeat (3) @(negedge clk);
        chk(nwr == wr0, "R10 no write", 32'(nwr), 32'(wr0));
        for (int i = 0; i < 16; i++) begin
            chk(D[i] === d0[i], "R10 data regs", D[i], d0[i]);
            chk(A[i] === a0[i], "R10 addr regs", A[i], a0[i]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog R5 actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        instr = 32'd0;
        for (int i = 0; i < 16; i++) begin
            D[i] = 32'h0D00_0000 + 32'(i) * 32'h111;
            A[i] = 32'h0000_4000 + 32'(i) * 32'h100;
        end
        A[2] = 32'h1000_0100;
        A[4] = 32'h2000_0000;
        A[5] = {16'd4, 16'd0};
        A[6] = 32'h3000_0000;
        A[7] = {16'd40, 16'd36};
        A[15] = 32'h5000_0000;
        A[0] = {16'd100, 16'd10};
        repeat (3) @(negedge clk);
        chk(!mem_req && !mem_lock && !done && !illegal && !dreg_we && !areg_we,
            "R1 reset quiet", {26'd0, mem_req, mem_lock, done, illegal, dreg_we, areg_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !done, "R1 after reset", {30'd0, mem_req, done}, 32'd0);

        run(mk_abs(4'd3, 18'h2_1234), 0);                  // R6: address 0x8000_1234
        chk(exp_ea == 32'h8000_1234, "R6 abs layout", exp_ea, 32'h8000_1234);
        run(mk_bo(8'h49, 6'h20, 4'd5, 4'd2, 10'h3F8), 2);  // R7 negative offset
        run(mk_bo(8'h49, 6'h20, 4'd0, 4'd9, 10'h1FF), 1);  // R7 positive offset
        run(mk_bo(8'h69, 6'h00, 4'd7, 4'd4, 10'h000), 1);  // R8 index 0 -> 4
        chk(A[5][15:0] == 16'd4, "R8 step one", {16'd0, A[5][15:0]}, 32'd4);
        run(mk_bo(8'h69, 6'h00, 4'd7, 4'd4, 10'h000), 0);  // R8 index 4 -> 2
        chk(A[5][15:0] == 16'd2, "R8 step two", {16'd0, A[5][15:0]}, 32'd2);
        run(mk_bo(8'h69, 6'h10, 4'd8, 4'd6, 10'd8), 1);    // R9 36+8 wraps to 4
        chk(A[7][15:0] == 16'd4, "R9 upper wrap", {16'd0, A[7][15:0]}, 32'd4);
        run(mk_bo(8'h69, 6'h10, 4'd8, 4'd6, 10'h3F8), 0);  // R9 4-8 wraps to 36
        chk(A[7][15:0] == 16'd36, "R9 lower wrap", {16'd0, A[7][15:0]}, 32'd36);
        run(mk_bo(8'h69, 6'h10, 4'd8, 4'd6, 10'd2), 2);    // R9 no wrap -> 38
        run(mk_bo(8'h69, 6'h10, 4'd1, 4'd15, 10'd5), 1);   // R12 pair of 15 is 0
        chk(A[0][15:0] == 16'd15, "R12 pair wraps to 0", {16'd0, A[0][15:0]}, 32'd15);

        run_bad(mk_bo(8'h49, 6'h21, 4'd1, 4'd2, 10'd3));   // R10
        run_bad(mk_abs(4'd2, 18'h0_0010) | 32'h0400_0000); // R10
        run_bad(mk_bo(8'h69, 6'h20, 4'd1, 4'd2, 10'd3));   // R10
        run_bad(32'h0000_0300);                            // R10

        run_busy(mk_bo(8'h49, 6'h20, 4'd2, 4'd3, 10'd4), mk_abs(4'd4, 18'h0_0200), 3); // R11

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule